// File: doc/BRIEF.md
# Oscillator Enable and Stabilization Timer

This block holds an 8-bit control register for three clock oscillators: an internal fast one, an external fast one and a slow one. Each has an enable bit. Each of the two fast oscillators also has a two-bit code that selects how long its stabilization wait lasts. When software turns an oscillator on, a per-oscillator counter counts that oscillator's cycles, which arrive as tick inputs. Once the programmed number of cycles has passed, the counter raises a ready flag. Clock-select logic downstream uses the ready flags to decide when a source may be switched in.

The clock selector reports which oscillators currently feed the system clock. The enable bit of such an oscillator cannot be cleared by a write. The wait length is captured at the moment the oscillator is switched on, so reprogramming a wait code does not change a count that is already running. The slow oscillator has no wait code; its wait length is a parameter.

Top module: `osc_stab_ctl`

## Requirements
- R1: After reset the internal fast enable (bit 2) is 1, the slow enable (bit 1) and external fast enable (bit 0) are 0, both wait codes are 0 and all ready flags are 0. The internal fast counter starts from reset with a 64-cycle wait.
- R2: A read returns {internal code in bits 7:6, external code in bits 5:4, 0 in bit 3, enables in bits 2:0} on the clock edge that samples the read strobe. Between reads the value holds.
- R3: Bit 3 reads as 0 whatever value was written to it.
- R4: The internal fast wait is 8, 16, 32 or 64 ticks for codes 3, 2, 1 and 0.
- R5: The external fast wait is 128, 256, 512 or 1024 ticks for codes 3, 2, 1 and 0.
- R6: The slow oscillator's wait is SLOW_WAIT ticks, 256 by default.
- R7: While an oscillator's in-use flag is high, a write that clears its enable bit leaves the bit at 1. The other bits of that write still take effect.
- R8: Clearing an enable drops that ready flag on the same edge. A later enable restarts the full wait from zero.
- R9: A counter advances only on its own oscillator's tick. Idle cycles and other oscillators' ticks do not move it.
- R10: The wait length is captured by the write that sets the enable bit from 0 to 1. A write that changes the wait code while the bit stays 1 neither restarts the count nor changes its length.
- R11: The ready flag rises on the clock edge that samples the final required tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_en | input | 1 | Register read strobe |
| in_use | input | 3 | Oscillator currently feeds the system clock (bit index as enables) |
| tick | input | 3 | One-cycle pulse per oscillator cycle (bit index as enables) |
| osc_en | output | 3 | Enable bits: 2 internal fast, 1 slow, 0 external fast |
| osc_ready | output | 3 | Stabilization done per oscillator |
| rd_data | output | 8 | Registered read value |

## Verification
Some properties are checked on every cycle:
- the reset state;
- bit 3 reading as 0;
- read data tracking the enables;
- an in-use enable never falling;
- a ready flag rising only after that oscillator's tick;
- ready being low right after an enable rises.

The exact wait lengths for every code can only be shown by the bench's tick-counting scenarios. The same holds for the wait being captured at enable time, for the restart after a disable, and for the count staying put on foreign ticks.

// File: rtl/osc_stab_pkg.sv
package osc_stab_pkg;
  localparam int NUM_OSC = 3;
  localparam int IDX_EXT  = 0;
  localparam int IDX_SLOW = 1;
  localparam int IDX_INT  = 2;
  localparam int RSV_BIT  = 3;

  // wait length: largest code gives the base, each lower code doubles it
  function automatic int unsigned wait_len(input int unsigned base, input logic [1:0] code);
    return base << (2'd3 - code);
  endfunction
endpackage

// File: rtl/osc_ctl_reg.sv
module osc_ctl_reg
  import osc_stab_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic [NUM_OSC-1:0] in_use,
  output logic [NUM_OSC-1:0] en,
  output logic [1:0]         int_code,
  output logic [1:0]         ext_code,
  output logic [NUM_OSC-1:0] start
);
  logic [NUM_OSC-1:0] en_next;

  always_comb begin
    en_next = wr_data[NUM_OSC-1:0] | (en & in_use);
    start   = wr_en ? (en_next & ~en) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 3'b100;
      int_code <= 2'd0;
      ext_code <= 2'd0;
    end else if (wr_en) begin
      en       <= en_next;
      int_code <= wr_data[7:6];
      ext_code <= wr_data[5:4];
    end
  end
endmodule

// File: rtl/osc_stab_timer.sv
module osc_stab_timer #(
  parameter int CW      = 11,
  parameter int RST_LEN = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] len,
  output logic          ready
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      lim   <= CW'(RST_LEN);
      rdy_q <= 1'b0;
    end else if (start) begin
      cnt   <= '0;
      lim   <= len;
      rdy_q <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      rdy_q <= 1'b0;
    end else if (tick && !rdy_q) begin
      cnt <= cnt + 1'b1;
      if (cnt + 1'b1 == lim) rdy_q <= 1'b1;
    end
  end

  assign ready = rdy_q & en;
endmodule

// File: rtl/osc_stab_ctl.sv
module osc_stab_ctl
  import osc_stab_pkg::*;
#(
  parameter int INT_BASE  = 8,
  parameter int EXT_BASE  = 128,
  parameter int SLOW_WAIT = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [2:0] in_use,
  input  logic [2:0] tick,
  output logic [2:0] osc_en,
  output logic [2:0] osc_ready,
  output logic [7:0] rd_data
);
  localparam int MAX_A   = (INT_BASE * 8 > EXT_BASE * 8) ? INT_BASE * 8 : EXT_BASE * 8;
  localparam int MAX_LEN = (MAX_A > SLOW_WAIT) ? MAX_A : SLOW_WAIT;
  localparam int CW      = $clog2(MAX_LEN) + 1;

  logic [1:0]         int_code, ext_code;
  logic [NUM_OSC-1:0] start;
  logic [CW-1:0]      len [NUM_OSC];

  osc_ctl_reg u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .in_use(in_use),
    .en(osc_en), .int_code(int_code), .ext_code(ext_code), .start(start)
  );

  always_comb begin
    len[IDX_INT]  = CW'(wait_len(INT_BASE, wr_data[7:6]));
    len[IDX_EXT]  = CW'(wait_len(EXT_BASE, wr_data[5:4]));
    len[IDX_SLOW] = CW'(SLOW_WAIT);
  end

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_tmr
    localparam int RL = (g == IDX_INT) ? INT_BASE * 8 :
                        (g == IDX_EXT) ? EXT_BASE * 8 : SLOW_WAIT;
    osc_stab_timer #(.CW(CW), .RST_LEN(RL)) u_tmr (
      .clk(clk), .rst(rst), .start(start[g]), .en(osc_en[g]),
      .tick(tick[g]), .len(len[g]), .ready(osc_ready[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= {int_code, ext_code, 1'b0, osc_en};
  end
endmodule

// File: rtl/osc_stab_chk.sv
module osc_stab_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_en,
  input logic [2:0] in_use,
  input logic [2:0] tick,
  input logic [2:0] osc_en,
  input logic [2:0] osc_ready,
  input logic [7:0] rd_data
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (osc_en == 3'b100 && osc_ready == 3'b000));
  // R3
  rsv_zero_chk: assert property (@(posedge clk) disable iff (rst) rd_data[3] == 1'b0);
  // R2
  rd_track_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data[2:0] == $past(osc_en));
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  for (genvar g = 0; g < 3; g++) begin : g_chk
    // R7
    in_use_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (osc_en[g] && in_use[g]) |=> osc_en[g]);
    // R9
    tick_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(osc_ready[g]) |-> $past(tick[g]));
    // R8
    fresh_en_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(osc_en[g]) |-> !osc_ready[g]);
  end
endmodule

bind osc_stab_ctl osc_stab_chk i_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .in_use(in_use), .tick(tick),
  .osc_en(osc_en), .osc_ready(osc_ready), .rd_data(rd_data)
);

// File: tb/test_osc_stab_ctl.sv
module test_osc_stab_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [2:0] in_use = '0, tick = '0;
  logic [2:0] osc_en, osc_ready;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  osc_stab_ctl i_osc_stab_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .in_use(in_use), .tick(tick), .osc_en(osc_en), .osc_ready(osc_ready), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk) tick[idx] = 1'b1;
    @(negedge clk) tick[idx] = 1'b0;
  endtask

  // counts ticks until ready; ready must appear exactly at the exp-th tick
  task automatic measure(input int idx, input int exp, input string req);
    int n = 0;
    for (int k = 1; k <= exp + 4 && n == 0; k++) begin
      pulse(idx);
      if (osc_ready[idx]) n = k;
    end
    check(n == exp, req, n, exp);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(osc_en == 3'b100, "R1 enables", osc_en, 4);
    check(osc_ready == 3'b000, "R1 ready", osc_ready, 0);
    rd(r);
    check(r == 8'h04, "R2 reset read", r, 4);
    measure(2, 64, "R1 internal wait from reset");

    // R4 internal codes, R8 disable drops ready
    for (int c = 0; c < 4; c++) begin
      wr(8'h00);
      check(osc_en[2] == 1'b0 && osc_ready[2] == 1'b0, "R8 disable clears ready", osc_ready[2], 0);
      wr(8'(c << 6) | 8'h04);
      rd(r);
      check(r == (8'(c << 6) | 8'h04), "R2 readback internal", r, 8'(c << 6) | 8'h04);
      measure(2, 8 << (3 - c), "R4 internal wait");
    end

    // R5 external codes
    for (int c = 0; c < 4; c++) begin
      wr(8'h00);
      wr(8'(c << 4) | 8'h01);
      rd(r);
      check(r == (8'(c << 4) | 8'h01), "R2 readback external", r, 8'(c << 4) | 8'h01);
      measure(0, 128 << (3 - c), "R5 external wait");
    end

    // R6 slow
    wr(8'h00);
    wr(8'h02);
    measure(1, 256, "R6 slow wait");

    // R3 reserved bit
    wr(8'hFF);
    rd(r);
    check(r == 8'hF7, "R3 reserved reads zero", r, 8'hF7);
    wr(8'h00);
    rd(r);
    check(r == 8'h00, "R2 all cleared", r, 0);

    // R7 in-use protection
    wr(8'h07);
    @(negedge clk) in_use = 3'b110;
    wr(8'h00);
    check(osc_en == 3'b110, "R7 in-use bits kept", osc_en, 6);
    @(negedge clk) in_use = 3'b001;
    wr(8'h00);
    check(osc_en == 3'b000, "R7 released bits clear", osc_en, 0);
    wr(8'h01);
    wr(8'h00);
    check(osc_en == 3'b001, "R7 external kept", osc_en, 1);
    @(negedge clk) in_use = 3'b000;
    wr(8'h00);
    check(osc_en == 3'b000, "R7 external cleared after release", osc_en, 0);

    // R9 only own ticks count
    wr(8'hC4);
    for (int k = 0; k < 20; k++) @(negedge clk) tick = 3'b011;
    @(negedge clk) tick = 3'b000;
    repeat (20) @(negedge clk);
    check(osc_ready[2] == 1'b0, "R9 foreign ticks ignored", osc_ready[2], 0);
    measure(2, 8, "R9 own ticks only");

    // R10 wait latched at enable, no restart on rewrite
    wr(8'h00);
    wr(8'hC4);
    repeat (3) pulse(2);
    wr(8'h04);
    rd(r);
    check(r == 8'h04, "R10 code rewrite visible", r, 4);
    measure(2, 5, "R10 latched wait continues");

    // R8 restart after disable, R11 exact edge
    wr(8'h04);
    repeat (7) pulse(2);
    wr(8'h00);
    wr(8'h04);
    measure(2, 64, "R8 full restart");
    wr(8'h00);
    wr(8'hC4);
    repeat (7) pulse(2);
    check(osc_ready[2] == 1'b0, "R11 not ready before last tick", osc_ready[2], 0);
    pulse(2);
    check(osc_ready[2] == 1'b1, "R11 ready on last tick", osc_ready[2], 1);

    report();
  end
endmodule